// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a parallel flash and turns a stream of already-latched bus write cycles (address plus data word) into operation requests for the array engine. It follows the multi-cycle unlock handshake. It dispatches word program, sector erase, block erase, chip erase, erase suspend and erase resume. It also tracks which read view the host sees: plain array, identification, query table or security-ID space.

Each write reaches the block as a one-cycle `wr_valid` strobe. An accepted operation appears as a one-cycle `op_valid` pulse on the clock after the write that completes it, together with its kind, address and data. The array engine reports back through `eng_busy` and `eng_erasing`. The block turns away writes that arrive while the engine is busy. It also turns away operations aimed at the boot block while `wp_n` is low, and programs into a region whose erase is suspended.

Top module: `flash_cmd_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `op_valid` is 0, `mode` is 0 (array) and `suspended` is 0. A reset taken in the middle of a sequence, a suspend or a read mode drops all of it.
- R2: The writes 555h/AAh, 2AAh/55h and 555h/A0h, followed by any address/data write, give `op_valid`=1 with `op_kind`=1 (program) on the next cycle. `op_addr` and `op_data` carry that fourth write.
- R3: The unlock pair, then 555h/80h, then the unlock pair again, followed by a sixth write, start an erase. If the sixth write holds 50h, `op_kind` is 2 (sector). If it holds 30h, `op_kind` is 3 (block). If it holds 10h at 555h, `op_kind` is 4 (chip). `op_addr` carries the sixth write's address.
- R4: The unlock pair, followed by 555h with 90h, 98h or 88h, sets `mode` to 1 (ID), 2 (query) or 3 (security ID). The mode holds across later writes until it is left.
- R5: Data F0h leaves the read mode and returns `mode` to 0. It works as a single write at any address from idle, or as the third write after the unlock pair.
- R6: Any write that breaks an unlock or erase sequence before it completes ends the sequence with no operation and returns `mode` to 0.
- R7: While `eng_busy` is 1, every write other than B0h is ignored, including F0h. No operation is issued, `mode` does not change and the sequence does not advance.
- R8: B0h, written while `eng_busy` and `eng_erasing` are 1 and the running erase is a sector or block erase, gives `op_kind`=5 and sets `suspended`. After a chip erase, B0h is ignored.
- R9: While `suspended` is 1 and the engine is idle, a single write of 30h at any address gives `op_kind`=6 and clears `suspended`.
- R10: While `suspended` is 1, a program into the suspended sector or block (2K / 32K words) is rejected and a program elsewhere is accepted. Every erase sequence is rejected.
- R11: While `wp_n` is 0, a program, sector erase or block erase whose address lies in the 32K-word boot block is rejected, and a chip erase is always rejected. With the default parameter the boot block is the bottom of the address space.
- R12: Only the low 8 data bits and the low 11 address bits are compared against command codes and unlock addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; ends any sequence, mode or suspend |
| wr_valid | input | 1 | One-cycle strobe of a latched bus write |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DW | Data of the write |
| wp_n | input | 1 | Low protects the boot block |
| eng_busy | input | 1 | Array engine is running a program or erase |
| eng_erasing | input | 1 | The running operation is an erase |
| op_valid | output | 1 | One-cycle pulse: operation request |
| op_kind | output | 3 | 1 program, 2 sector erase, 3 block erase, 4 chip erase, 5 suspend, 6 resume |
| op_addr | output | AW | Address of the completing write |
| op_data | output | DW | Data of the completing write |
| mode | output | 2 | 0 array, 1 ID, 2 query, 3 security ID |
| suspended | output | 1 | An erase is suspended |

## Verification
Complete program and erase sequences are sent, and each one tells apart the three erase kinds by their sixth write. The same sequences are then repeated with one broken cycle, such as a wrong address or a wrong code in the sixth write, which separates a true abort from a silent ignore. Each sequence is also replayed with `eng_busy`, `suspended` or `wp_n` set, with target addresses inside and just outside the suspended region and the boot block, so that each filter is shown to act only on its own region. Writes whose upper data and address bits carry junk show that only the compared fields decide the result.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_SECT   = 3'd2,
    OP_BLK    = 3'd3,
    OP_CHIP   = 3'd4,
    OP_SUSP   = 3'd5,
    OP_RESUME = 3'd6
  } op_kind_e;

  typedef enum logic [1:0] {
    RM_ARRAY = 2'd0,
    RM_ID    = 2'd1,
    RM_QUERY = 2'd2,
    RM_SECID = 2'd3
  } rd_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PGM,
    SQ_ERA3,
    SQ_ERA4,
    SQ_ERA5
  } seq_e;

  localparam logic [7:0] C_KEY1    = 8'hAA;
  localparam logic [7:0] C_KEY2    = 8'h55;
  localparam logic [7:0] C_PROG    = 8'hA0;
  localparam logic [7:0] C_ERASE   = 8'h80;
  localparam logic [7:0] C_SECT    = 8'h50;
  localparam logic [7:0] C_BLK     = 8'h30;
  localparam logic [7:0] C_CHIP    = 8'h10;
  localparam logic [7:0] C_SUSP    = 8'hB0;
  localparam logic [7:0] C_RESUME  = 8'h30;
  localparam logic [7:0] C_ID      = 8'h90;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_SECID   = 8'h88;
  localparam logic [7:0] C_EXIT    = 8'hF0;

  localparam logic [31:0] KEY_ADDR1 = 32'h555;
  localparam logic [31:0] KEY_ADDR2 = 32'h2AA;

  // True when both addresses fall in the same aligned span of 2**sh words.
  function automatic logic same_span(input logic [31:0] a, input logic [31:0] b,
                                     input int unsigned sh);
    return (a >> sh) == (b >> sh);
  endfunction

  function automatic logic is_erase(input op_kind_e k);
    return (k == OP_SECT) || (k == OP_BLK) || (k == OP_CHIP);
  endfunction

endpackage

// File: rtl/fcs_seq_tracker.sv
module fcs_seq_tracker
  import flash_cmd_pkg::*;
#(
  parameter int KEY_BITS = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  input  logic [KEY_BITS-1:0] key_addr,
  input  logic [7:0]          cmd_byte,
  input  logic                eng_busy,
  input  logic                suspended,
  output op_kind_e            cand_kind,
  output logic                mode_set,
  output rd_mode_e            mode_val,
  output logic                seq_abort
);

  localparam logic [KEY_BITS-1:0] K1 = KEY_BITS'(KEY_ADDR1);
  localparam logic [KEY_BITS-1:0] K2 = KEY_BITS'(KEY_ADDR2);

  seq_e st_q, st_d;
  logic at_k1, at_k2;

  assign at_k1 = (key_addr == K1);
  assign at_k2 = (key_addr == K2);

  always_comb begin
    st_d      = st_q;
    cand_kind = OP_NONE;
    mode_set  = 1'b0;
    mode_val  = RM_ARRAY;
    seq_abort = 1'b0;
    if (wr_valid) begin
      if (eng_busy) begin
        if (cmd_byte == C_SUSP) cand_kind = OP_SUSP;
      end else begin
        unique case (st_q)
          SQ_IDLE: begin
            if (at_k1 && cmd_byte == C_KEY1)           st_d = SQ_UNL1;
            else if (cmd_byte == C_EXIT)               mode_set = 1'b1;
            else if (suspended && cmd_byte == C_RESUME) cand_kind = OP_RESUME;
          end
          SQ_UNL1: begin
            if (at_k2 && cmd_byte == C_KEY2) st_d = SQ_UNL2;
            else                             seq_abort = 1'b1;
          end
          SQ_UNL2: begin
            st_d = SQ_IDLE;
            if (!at_k1) seq_abort = 1'b1;
            else begin
              unique case (cmd_byte)
                C_PROG:  st_d = SQ_PGM;
                C_ERASE: st_d = SQ_ERA3;
                C_ID:    begin mode_set = 1'b1; mode_val = RM_ID;    end
                C_QUERY: begin mode_set = 1'b1; mode_val = RM_QUERY; end
                C_SECID: begin mode_set = 1'b1; mode_val = RM_SECID; end
                C_EXIT:  mode_set = 1'b1;
                default: seq_abort = 1'b1;
              endcase
            end
          end
          SQ_PGM: begin
            st_d      = SQ_IDLE;
            cand_kind = OP_PROG;
          end
          SQ_ERA3: begin
            if (at_k1 && cmd_byte == C_KEY1) st_d = SQ_ERA4;
            else                             seq_abort = 1'b1;
          end
          SQ_ERA4: begin
            if (at_k2 && cmd_byte == C_KEY2) st_d = SQ_ERA5;
            else                             seq_abort = 1'b1;
          end
          SQ_ERA5: begin
            st_d = SQ_IDLE;
            if (cmd_byte == C_SECT)               cand_kind = OP_SECT;
            else if (cmd_byte == C_BLK)           cand_kind = OP_BLK;
            else if (cmd_byte == C_CHIP && at_k1) cand_kind = OP_CHIP;
            else                                  seq_abort = 1'b1;
          end
          default: seq_abort = 1'b1;
        endcase
        if (seq_abort) begin
          st_d     = SQ_IDLE;
          mode_set = 1'b1;
          mode_val = RM_ARRAY;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/fcs_op_filter.sv
module fcs_op_filter
  import flash_cmd_pkg::*;
#(
  parameter int AW        = 22,
  parameter int SECT_BITS = 11,
  parameter int BLK_BITS  = 15,
  parameter bit BOOT_TOP  = 1'b0
) (
  input  op_kind_e        cand_kind,
  input  logic [AW-1:0]   wr_addr,
  input  logic            wp_n,
  input  logic            eng_erasing,
  input  logic            suspended,
  input  logic            susp_is_block,
  input  logic [AW-1:0]   susp_addr,
  input  logic            erase_can_susp,
  output logic            accept,
  output logic            reject
);

  localparam int BIDX_W = AW - BLK_BITS;

  logic [BIDX_W-1:0] blk_idx;
  logic              boot_hit;
  logic              in_susp_region;

  assign blk_idx = wr_addr[AW-1:BLK_BITS];

  generate
    if (BOOT_TOP) begin : g_boot_top
      assign boot_hit = &blk_idx;
    end else begin : g_boot_bottom
      assign boot_hit = ~|blk_idx;
    end
  endgenerate

  assign in_susp_region = same_span(32'(wr_addr), 32'(susp_addr),
                                    susp_is_block ? BLK_BITS : SECT_BITS);

  always_comb begin
    reject = 1'b0;
    unique case (cand_kind)
      OP_PROG:         reject = (!wp_n && boot_hit) || (suspended && in_susp_region);
      OP_SECT, OP_BLK: reject = suspended || (!wp_n && boot_hit);
      OP_CHIP:         reject = suspended || !wp_n;
      OP_SUSP:         reject = !eng_erasing || suspended || !erase_can_susp;
      default:         reject = 1'b0;
    endcase
    accept = (cand_kind != OP_NONE) && !reject;
  end

endmodule

// File: rtl/fcs_ctrl_regs.sv
module fcs_ctrl_regs
  import flash_cmd_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  op_kind_e        cand_kind,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            mode_set,
  input  rd_mode_e        mode_val,
  output logic            op_valid,
  output logic [2:0]      op_kind,
  output logic [AW-1:0]   op_addr,
  output logic [DW-1:0]   op_data,
  output logic [1:0]      mode,
  output logic            suspended,
  output logic [AW-1:0]   susp_addr,
  output logic            susp_is_block,
  output logic            erase_can_susp
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_valid       <= 1'b0;
      op_kind        <= OP_NONE;
      op_addr        <= '0;
      op_data        <= '0;
      mode           <= RM_ARRAY;
      suspended      <= 1'b0;
      susp_addr      <= '0;
      susp_is_block  <= 1'b0;
      erase_can_susp <= 1'b0;
    end else begin
      op_valid <= accept;
      if (accept) begin
        op_kind <= cand_kind;
        op_addr <= wr_addr;
        op_data <= wr_data;
        unique case (cand_kind)
          OP_SECT: begin
            erase_can_susp <= 1'b1;
            susp_addr      <= wr_addr;
            susp_is_block  <= 1'b0;
          end
          OP_BLK: begin
            erase_can_susp <= 1'b1;
            susp_addr      <= wr_addr;
            susp_is_block  <= 1'b1;
          end
          OP_CHIP:   erase_can_susp <= 1'b0;
          OP_SUSP:   suspended      <= 1'b1;
          OP_RESUME: suspended      <= 1'b0;
          default:   ;
        endcase
      end
      if (mode_set) mode <= mode_val;
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW        = 22,
  parameter int DW        = 16,
  parameter int KEY_BITS  = 11,
  parameter int SECT_BITS = 11,
  parameter int BLK_BITS  = 15,
  parameter bit BOOT_TOP  = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            wp_n,
  input  logic            eng_busy,
  input  logic            eng_erasing,
  output logic            op_valid,
  output logic [2:0]      op_kind,
  output logic [AW-1:0]   op_addr,
  output logic [DW-1:0]   op_data,
  output logic [1:0]      mode,
  output logic            suspended
);

  // Internal events, named for the checker.
  op_kind_e          cand_kind;
  logic              mode_set;
  rd_mode_e          mode_val;
  logic              seq_abort;
  logic              cand_accept;
  logic              cand_reject;
  logic [AW-1:0]     susp_addr;
  logic              susp_is_block;
  logic              erase_can_susp;

  fcs_seq_tracker #(.KEY_BITS(KEY_BITS)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .key_addr  (wr_addr[KEY_BITS-1:0]),
    .cmd_byte  (wr_data[7:0]),
    .eng_busy  (eng_busy),
    .suspended (suspended),
    .cand_kind (cand_kind),
    .mode_set  (mode_set),
    .mode_val  (mode_val),
    .seq_abort (seq_abort)
  );

  fcs_op_filter #(
    .AW(AW), .SECT_BITS(SECT_BITS), .BLK_BITS(BLK_BITS), .BOOT_TOP(BOOT_TOP)
  ) u_flt (
    .cand_kind      (cand_kind),
    .wr_addr        (wr_addr),
    .wp_n           (wp_n),
    .eng_erasing    (eng_erasing),
    .suspended      (suspended),
    .susp_is_block  (susp_is_block),
    .susp_addr      (susp_addr),
    .erase_can_susp (erase_can_susp),
    .accept         (cand_accept),
    .reject         (cand_reject)
  );

  fcs_ctrl_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .accept         (cand_accept),
    .cand_kind      (cand_kind),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .mode_set       (mode_set),
    .mode_val       (mode_val),
    .op_valid       (op_valid),
    .op_kind        (op_kind),
    .op_addr        (op_addr),
    .op_data        (op_data),
    .mode           (mode),
    .suspended      (suspended),
    .susp_addr      (susp_addr),
    .susp_is_block  (susp_is_block),
    .erase_can_susp (erase_can_susp)
  );

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic [7:0] cmd_byte,
  input logic       wp_n,
  input logic       eng_busy,
  input logic       op_valid,
  input logic [2:0] op_kind,
  input logic [1:0] mode,
  input logic       suspended,
  input logic       seq_abort,
  input logic       cand_reject
);

  a_r2_op_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $past(wr_valid));

  a_r7_busy_blocks_ops: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && wr_valid && cmd_byte != 8'hB0) |=> !op_valid);

  a_r7_busy_holds_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && wr_valid) |=> $stable(mode));

  a_r6_abort_to_array: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |=> (mode == 2'd0 && !op_valid));

  a_r11_chip_needs_wp: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 3'd4) |-> $past(wp_n));

  a_r8_suspend_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 3'd5) |-> suspended);

  a_r9_resume_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 3'd6) |-> !suspended);

  a_r10_no_erase_when_susp: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_kind == 3'd2 || op_kind == 3'd3 || op_kind == 3'd4))
      |-> !$past(suspended));

  a_r10_reject_no_op: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && cand_reject) |=> !op_valid);

endmodule

bind flash_cmd_seq fcs_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .cmd_byte    (wr_data[7:0]),
  .wp_n        (wp_n),
  .eng_busy    (eng_busy),
  .op_valid    (op_valid),
  .op_kind     (op_kind),
  .mode        (mode),
  .suspended   (suspended),
  .seq_abort   (seq_abort),
  .cand_reject (cand_reject)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [21:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wp_n = 1'b1;
  logic        eng_busy = 1'b0;
  logic        eng_erasing = 1'b0;
  logic        op_valid;
  logic [2:0]  op_kind;
  logic [21:0] op_addr;
  logic [15:0] op_data;
  logic [1:0]  mode;
  logic        suspended;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wp_n(wp_n), .eng_busy(eng_busy),
    .eng_erasing(eng_erasing), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .mode(mode), .suspended(suspended)
  );

  typedef struct packed {
    logic [21:0] a;
    logic [15:0] d;
    logic        wp;
    logic        bz;
    logic        er;
    logic        ev;
    logic [2:0]  k;
    logic [1:0]  m;
    logic        s;
  } vec_t;

  localparam int NV = 41;
  localparam vec_t TBL [NV] = '{
    '{22'h000555, 16'h00AA, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0}, // R2
    '{22'h0002AA, 16'h0055, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0},
    '{22'h000555, 16'h00A0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0},
    '{22'h001234, 16'hBEEF, 1'b1, 1'b0, 1'b0, 1'b1, 3'd1, 2'd0, 1'b0}, // R2 program
    '{22'h000555, 16'h00AA, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0}, // R3
    '{22'h0002AA, 16'h0055, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0},
    '{22'h000555, 16'h0080, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0},
    '{22'h000555, 16'h00AA, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0},
    '{22'h0002AA, 16'h0055, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0},
    '{22'h00C800, 16'h0050, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2, 2'd0, 1'b0}, // R3 sector
    '{22'h000555, 16'h00AA, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 2'd0, 1'b0}, // R7 ignored
    '{22'h000123, 16'h00B0, 1'b1, 1'b1, 1'b1, 1'b1, 3'd5, 2'd0, 1'b1}, // R8 suspend
    '{22'h000555, 16'h00AA, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1}, // R10
    '{22'h0002AA, 16'h0055, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1},
    '{22'h000555, 16'h00A0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1},
    '{22'h00C9FF, 16'h1111, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1}, // R10 same sector
    '{22'h000555, 16'h00AA, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1},
    '{22'h0002AA, 16'h0055, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1},
    '{22'h000555, 16'h00A0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1},
    '{22'h00D000, 16'h2222, 1'b1, 1'b0, 1'b0, 1'b1, 3'd1, 2'd0, 1'b1}, // R10 next sector
    '{22'h000555, 16'h00AA, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1},
    '{22'h0002AA, 16'h0055, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1},
    '{22'h000555, 16'h0080, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1},
    '{22'h000555, 16'h00AA, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1},
    '{22'h0002AA, 16'h0055, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1},
    '{22'h00E000, 16'h0030, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1}, // R10 erase rejected
    '{22'h0007FF, 16'h0030, 1'b1, 1'b0, 1'b0, 1'b1, 3'd6, 2'd0, 1'b0}, // R9 resume
    '{22'h000555, 16'h00AA, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0}, // R4
    '{22'h0002AA, 16'h0055, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0},
    '{22'h000555, 16'h0090, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd1, 1'b0}, // R4 ID
    '{22'h000000, 16'h00F0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0}, // R5 exit
    '{22'h000555, 16'h00AA, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0},
    '{22'h0002AA, 16'h0055, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0},
    '{22'h000555, 16'h0098, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd2, 1'b0}, // R4 query
    '{22'h000555, 16'h00AA, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd2, 1'b0}, // R4 holds
    '{22'h000123, 16'h0055, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0}, // R6 abort
    '{22'h000555, 16'h00AA, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0},
    '{22'h0002AA, 16'h0055, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0},
    '{22'h000555, 16'h0088, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd3, 1'b0}, // R4 security ID
    '{22'h000000, 16'h00F0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 2'd3, 1'b0}, // R7 exit ignored
    '{22'h000000, 16'h00F0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0}  // R5 exit
  };

  task automatic wr(input logic [21:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_addr  = a;
    wr_data  = d;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic unlock3(input logic [15:0] c);
    wr(22'h000555, 16'h00AA);
    wr(22'h0002AA, 16'h0055);
    wr(22'h000555, c);
  endtask

  task automatic erase6(input logic [21:0] a, input logic [15:0] c);
    unlock3(16'h0080);
    wr(22'h000555, 16'h00AA);
    wr(22'h0002AA, 16'h0055);
    wr(a, c);
  endtask

  task automatic chk(input string tag, input logic ev, input logic [2:0] k,
                     input logic [1:0] m, input logic s);
    n_cmp++;
    if (op_valid !== ev || (ev && op_kind !== k) || mode !== m || suspended !== s) begin
      n_bad++;
      $display("FAIL %s: got v=%b k=%0d m=%0d s=%b expected v=%b k=%0d m=%0d s=%b",
               tag, op_valid, op_kind, mode, suspended, ev, k, m, s);
    end
  endtask

  task automatic chk_ad(input string tag, input logic [21:0] a, input logic [15:0] d);
    n_cmp++;
    if (op_addr !== a || op_data !== d) begin
      n_bad++;
      $display("FAIL %s: got addr=%h data=%h expected addr=%h data=%h",
               tag, op_addr, op_data, a, d);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got no completion expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 during reset", 1'b0, 3'd0, 2'd0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 1'b0, 3'd0, 2'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      wp_n        = TBL[i].wp;
      eng_busy    = TBL[i].bz;
      eng_erasing = TBL[i].er;
      wr(TBL[i].a, TBL[i].d);
      chk($sformatf("table row %0d", i), TBL[i].ev, TBL[i].k, TBL[i].m, TBL[i].s);
      if (i == 3) chk_ad("R2 program addr/data", 22'h001234, 16'hBEEF);
    end
    eng_busy = 1'b0;
    eng_erasing = 1'b0;

    // R11: boot block protection, default bottom placement
    wp_n = 1'b0;
    unlock3(16'h00A0); wr(22'h000100, 16'h1234);
    chk("R11 program in boot", 1'b0, 3'd0, 2'd0, 1'b0);
    erase6(22'h004000, 16'h0030);
    chk("R11 block erase boot", 1'b0, 3'd0, 2'd0, 1'b0);
    erase6(22'h000800, 16'h0050);
    chk("R11 sector erase boot", 1'b0, 3'd0, 2'd0, 1'b0);
    erase6(22'h000555, 16'h0010);
    chk("R11 chip erase", 1'b0, 3'd0, 2'd0, 1'b0);
    unlock3(16'h00A0); wr(22'h008000, 16'h5678);
    chk("R11 program outside boot", 1'b1, 3'd1, 2'd0, 1'b0);
    chk_ad("R11 program outside boot addr", 22'h008000, 16'h5678);
    wp_n = 1'b1;

    // R3 chip erase, then R8 suspend refused after chip erase
    erase6(22'h000555, 16'h0010);
    chk("R3 chip erase", 1'b1, 3'd4, 2'd0, 1'b0);
    eng_busy = 1'b1; eng_erasing = 1'b1;
    wr(22'h000123, 16'h00B0);
    chk("R8 no suspend of chip erase", 1'b0, 3'd0, 2'd0, 1'b0);
    eng_busy = 1'b0; eng_erasing = 1'b0;

    // R12: junk in upper data and address bits
    wr(22'h3FF555, 16'h12AA);
    wr(22'h2002AA, 16'hFF55);
    wr(22'h155555, 16'h7FA0);
    wr(22'h000050, 16'h0000);
    chk("R12 upper bits ignored", 1'b1, 3'd1, 2'd0, 1'b0);

    // R3 block erase with address
    erase6(22'h018000, 16'h0030);
    chk("R3 block erase", 1'b1, 3'd3, 2'd0, 1'b0);
    chk_ad("R3 block erase addr", 22'h018000, 16'h0030);

    // R6: chip code at wrong address aborts, from ID mode
    unlock3(16'h0090);
    chk("R4 ID again", 1'b0, 3'd0, 2'd1, 1'b0);
    erase6(22'h000123, 16'h0010);
    chk("R6 bad sixth cycle", 1'b0, 3'd0, 2'd0, 1'b0);

    // R5 three-cycle exit
    unlock3(16'h0098);
    unlock3(16'h00F0);
    chk("R5 three-cycle exit", 1'b0, 3'd0, 2'd0, 1'b0);

    // R1: reset drops suspend and mode
    erase6(22'h00C800, 16'h0050);
    eng_busy = 1'b1; eng_erasing = 1'b1;
    wr(22'h000000, 16'h00B0);
    eng_busy = 1'b0; eng_erasing = 1'b0;
    unlock3(16'h0090);
    chk("R1 pre-reset state", 1'b0, 3'd0, 2'd1, 1'b1);
    do_reset();
    chk("R1 reset mid-suspend", 1'b0, 3'd0, 2'd0, 1'b0);

    finished = 1'b1;
    summary();
  end

endmodule